// File: doc/BRIEF.md
# Link Event Counter Unit

This block counts traffic events for an inter-socket serial link. It has eight 64-bit counters, read and programmed over a simple 32-bit register port. Each counter takes one of sixteen level-type event inputs, picked by a 10-bit selector. It counts in one of three ways: once per cycle while the input is high, once per rising edge, or once per falling edge.

A single run controller governs all counters. It has four states:
- `ST_OFF`: not enabled.
- `ST_ARMED`: enabled, not started.
- `ST_COUNT`: enabled and started; the only state in which counters advance.
- `ST_CLEAR`: a one-cycle state that zeroes every counter.

A write to the control register moves the controller:
- With the clear bit set, it goes to `ST_CLEAR`.
- Otherwise, the enable and start bits choose among the other three states.

From `ST_CLEAR` the controller falls through, on the next cycle, to the state that the stored enable and start bits select.

Software reads a 64-bit counter in three steps. First it writes the counter number plus eight to the select register. Next it reads the high word, which also captures the whole value. Last it reads the low word, which returns the lower half of that captured value.

Top module: `lec_unit`

## Requirements
- R1: After reset, every register reads 0, every counter is 0, reg_rvalid is low and reg_rdata is 0.
- R2: The control register at 0x108 stores enable (bit 0) and start (bit 1). Both bits read back, and all other bits read 0. Counters advance only while both bits are 1. A write of start without enable does not count.
- R3: A control write with bit 4 set enters the clear state for one cycle. In the clock edge after the write, all counters become 0 and no event is counted. Counting resumes on the following edge if enable and start are set. Bit 4 always reads back as 0.
- R4: A control write of 0 stops counting, and the counter values hold. Enable without start holds them too. A later write of 0x3 without bit 4 continues from the held values.
- R5: The configuration register of counter i sits at 0x10C + 4*i. Bits [11:0] read back as written, and all higher bits are dropped and read 0.
- R6: With configuration bit 11 clear, the counter adds 1 on every clock edge at which its selected input is high. The input index is the selector value (bits [9:0]) modulo 16.
- R7: With bits 11 and 10 both set, the counter adds 1 on each edge at which its input is high and was low at the previous edge.
- R8: With bit 11 set and bit 10 clear, the counter adds 1 on each edge at which its input is low and was high at the previous edge.
- R9: The select register at 0x12C stores and reads back all 32 bits. The value 8 + i selects counter i.
- R10: A read at 0x134 returns bits [63:32] of the selected counter and captures its full value. A read at 0x130 returns bits [31:0] of the captured value, even if the counter has moved since the capture.
- R11: When the select register holds a value outside 8 to 15, reads at 0x130 and 0x134 return 0.
- R12: Read data appears with reg_rvalid exactly one cycle after reg_rd. Addresses with no register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| evt_in | input | 16 | Level event inputs |

## Verification
The assertions check the following on every cycle:
- Read latency is one cycle.
- The clear state lasts one cycle and leaves all counters at zero.
- Outside the counting state the counters do not change.
- Each counter moves by at most one per cycle.
- Out-of-range window reads and control readback return zeros where required.

Only the bench scenarios can show:
- The exact counts under the level, rising-edge and falling-edge modes.
- Selector wrap-around.
- The one-edge loss of counting right after a clear.
- The consistency of a high/low read pair while the counter keeps running.

// File: rtl/lec_pkg.sv
`timescale 1ns/1ps
package lec_pkg;
    localparam logic [11:0] ADDR_CTRL = 12'h108;
    localparam logic [11:0] ADDR_CFG0 = 12'h10C;
    localparam logic [11:0] ADDR_SEL  = 12'h12C;
    localparam logic [11:0] ADDR_DLO  = 12'h130;
    localparam logic [11:0] ADDR_DHI  = 12'h134;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_GO_BIT  = 1;
    localparam int CTRL_CLR_BIT = 4;

    localparam int CFG_W        = 12;
    localparam int CFG_POL_BIT  = 10;
    localparam int CFG_EDGE_BIT = 11;

    localparam int SEL_BASE = 8;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2,
        ST_CLEAR = 2'd3
    } run_state_e;
endpackage

// File: rtl/lec_run_fsm.sv
`timescale 1ns/1ps
module lec_run_fsm
    import lec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_en,
    input  logic ctl_go,
    input  logic ctl_clr,
    output logic en_q,
    output logic go_q,
    output logic run,
    output logic clr
);
    run_state_e state_q, state_d;

    function automatic run_state_e pick_mode(input logic en, input logic go);
        if (!en)     return ST_OFF;
        else if (go) return ST_COUNT;
        else         return ST_ARMED;
    endfunction

    // stored control bits (readback and fall-through target)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            go_q <= 1'b0;
        end else if (ctl_wr) begin
            en_q <= ctl_en;
            go_q <= ctl_go;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = ST_OFF;
            ST_ARMED: state_d = ST_ARMED;
            ST_COUNT: state_d = ST_COUNT;
            ST_CLEAR: state_d = pick_mode(en_q, go_q);
        endcase
        if (ctl_wr) begin
            state_d = ctl_clr ? ST_CLEAR : pick_mode(ctl_en, ctl_go);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        run = 1'b0;
        clr = 1'b0;
        unique case (state_q)
            ST_OFF:   run = 1'b0;
            ST_ARMED: run = 1'b0;
            ST_COUNT: run = 1'b1;
            ST_CLEAR: clr = 1'b1;
        endcase
    end
endmodule

// File: rtl/lec_event_ctr.sv
`timescale 1ns/1ps
module lec_event_ctr #(
    parameter int NUM_EVENTS = 16,
    parameter int CNT_W      = 64,
    localparam int IDX_W     = $clog2(NUM_EVENTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_in,
    input  logic [IDX_W-1:0]      src_idx,
    input  logic                  edge_mode,
    input  logic                  rise_pol,
    input  logic                  run,
    input  logic                  clr,
    output logic [CNT_W-1:0]      count
);
    logic lvl, prev_q, hit;

    assign lvl = evt_in[src_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        if (!edge_mode)    hit = lvl;
        else if (rise_pol) hit = lvl & ~prev_q;
        else               hit = ~lvl & prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr)  count <= '0;
        else if (run && hit) count <= count + 1'b1;
    end
endmodule

// File: rtl/lec_read_port.sv
`timescale 1ns/1ps
module lec_read_port
    import lec_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64,
    localparam int CIDX_W = $clog2(NUM_CNT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hi_rd,
    input  logic [31:0]                   sel_q,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnts,
    output logic [31:0]                   win_hi,
    output logic [31:0]                   win_lo
);
    logic [31:0]       rel;
    logic [CIDX_W-1:0] cidx;
    logic              in_range;
    logic [CNT_W-1:0]  picked;
    logic [31:0]       snap_lo_q;

    assign rel      = sel_q - 32'(SEL_BASE);
    assign in_range = (rel < 32'(NUM_CNT));
    assign cidx     = rel[CIDX_W-1:0];
    assign picked   = in_range ? cnts[cidx] : '0;

    assign win_hi = picked[CNT_W-1 -: 32];
    assign win_lo = in_range ? snap_lo_q : 32'd0;

    always_ff @(posedge clk) begin
        if (!rst_n)     snap_lo_q <= 32'd0;
        else if (hi_rd) snap_lo_q <= picked[31:0];
    end
endmodule

// File: rtl/lec_unit.sv
`timescale 1ns/1ps
module lec_unit
    import lec_pkg::*;
#(
    parameter int NUM_CNT    = 8,
    parameter int CNT_W      = 64,
    parameter int NUM_EVENTS = 16,
    localparam int IDX_W     = $clog2(NUM_EVENTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [11:0]           reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  reg_rvalid,
    input  logic [NUM_EVENTS-1:0] evt_in
);
    logic                          en_q, go_q, run, clr;
    logic                          ctl_wr;
    logic [NUM_CNT-1:0]            cfg_hit;
    logic [NUM_CNT-1:0][CFG_W-1:0] cfg_q;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnts;
    logic [31:0]                   sel_q;
    logic [31:0]                   win_hi, win_lo;
    logic [31:0]                   rd_mux;

    assign ctl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    lec_run_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .ctl_en  (reg_wdata[CTRL_EN_BIT]),
        .ctl_go  (reg_wdata[CTRL_GO_BIT]),
        .ctl_clr (reg_wdata[CTRL_CLR_BIT]),
        .en_q    (en_q),
        .go_q    (go_q),
        .run     (run),
        .clr     (clr)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_ctr
        assign cfg_hit[i] = (reg_addr == 12'(ADDR_CFG0 + 4 * i));

        always_ff @(posedge clk) begin
            if (!rst_n)                  cfg_q[i] <= '0;
            else if (reg_wr && cfg_hit[i]) cfg_q[i] <= reg_wdata[CFG_W-1:0];
        end

        lec_event_ctr #(
            .NUM_EVENTS (NUM_EVENTS),
            .CNT_W      (CNT_W)
        ) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_in    (evt_in),
            .src_idx   (cfg_q[i][IDX_W-1:0]),
            .edge_mode (cfg_q[i][CFG_EDGE_BIT]),
            .rise_pol  (cfg_q[i][CFG_POL_BIT]),
            .run       (run),
            .clr       (clr),
            .count     (cnts[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                   sel_q <= 32'd0;
        else if (reg_wr && (reg_addr == ADDR_SEL))    sel_q <= reg_wdata;
    end

    lec_read_port #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W)
    ) u_rport (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_rd  (reg_rd && (reg_addr == ADDR_DHI)),
        .sel_q  (sel_q),
        .cnts   (cnts),
        .win_hi (win_hi),
        .win_lo (win_lo)
    );

    always_comb begin
        rd_mux = 32'd0;
        if (reg_addr == ADDR_CTRL) rd_mux = {30'd0, go_q, en_q};
        if (reg_addr == ADDR_SEL)  rd_mux = sel_q;
        if (reg_addr == ADDR_DHI)  rd_mux = win_hi;
        if (reg_addr == ADDR_DLO)  rd_mux = win_lo;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (cfg_hit[i]) rd_mux = {20'd0, cfg_q[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= 32'd0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/lec_unit_checker.sv
`timescale 1ns/1ps
module lec_unit_checker
    import lec_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_rd,
    input logic                          reg_wr,
    input logic [11:0]                   reg_addr,
    input logic                          wr_clr_bit,
    input logic [31:0]                   reg_rdata,
    input logic                          reg_rvalid,
    input logic                          run,
    input logic                          clr,
    input logic [31:0]                   sel_q,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnts
);
    logic sel_out;
    assign sel_out = (sel_q < 32'(SEL_BASE)) || (sel_q >= 32'(SEL_BASE + NUM_CNT));

    p_read_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid)
        else $error("read data not valid one cycle after strobe");

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnts == '0))
        else $error("counters not zero after clear state");

    p_clear_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(reg_wr && reg_addr == ADDR_CTRL && wr_clr_bit)) |=> !clr)
        else $error("clear state held longer than one cycle");

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnts))
        else $error("counter moved while not counting");

    p_ctrl_rb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_CTRL) |=> (reg_rdata[31:2] == 30'd0))
        else $error("control readback has stray bits");

    p_oor_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel_out && (reg_addr == ADDR_DHI || reg_addr == ADDR_DLO))
            |=> (reg_rdata == 32'd0))
        else $error("data window not zero with select out of range");

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_step
        p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            run |=> (cnts[i] == $past(cnts[i]) || cnts[i] == $past(cnts[i]) + 1'b1))
            else $error("counter stepped by more than one");
    end
endmodule

bind lec_unit lec_unit_checker #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .wr_clr_bit (reg_wdata[4]),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .run        (run),
    .clr        (clr),
    .sel_q      (sel_q),
    .cnts       (cnts)
);

// File: tb/lec_unit_test.sv
`timescale 1ns/1ps
module lec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [15:0] evt_in = '0;

    int nchk = 0, nfail = 0;
    logic [31:0] q_exp[$];
    string       q_tag[$];
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    lec_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .evt_in(evt_in)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        q_exp.push_back(e); q_tag.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rdcnt(input int i, input logic [63:0] e, input string tag);
        wr(12'h12C, 32'(8 + i));
        rd(12'h134, e[63:32], tag);
        rd(12'h130, e[31:0], tag);
    endtask

    // starts at a negedge, leaves at a negedge
    task automatic pulse(input int bitn, input int n);
        evt_in[bitn] = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        evt_in[bitn] = 1'b0;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as read data comes back
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R12 unexpected read data", reg_rdata, 32'hx);
            end else begin
                logic [31:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(reg_rdata === e, t, reg_rdata, e);
            end
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_rvalid === 1'b0, "R1 rvalid after reset", 32'(reg_rvalid), 32'd0);
        check(reg_rdata === 32'd0, "R1 rdata after reset", reg_rdata, 32'd0);
        rd(12'h108, 32'd0, "R1 control reset value");
        rd(12'h10C, 32'd0, "R1 config reset value");
        rd(12'h12C, 32'd0, "R1 select reset value");
        rdcnt(0, 64'd0, "R1 counter reset value");

        // configuration (R5)
        wr(12'h10C, 32'h0000_003D);            // c0: level, input 13
        wr(12'h110, 32'h0000_0C65);            // c1: rising edge, input 5
        wr(12'h114, 32'h0000_0905);            // c2: falling edge, input 5
        wr(12'h118, 32'h0000_012D);            // c3: level, input 13
        wr(12'h11C, 32'hFFFF_F013);            // c4: level, input 3
        rd(12'h10C, 32'h0000_003D, "R5 config 0 readback");
        rd(12'h110, 32'h0000_0C65, "R5 config 1 readback");
        rd(12'h11C, 32'h0000_0013, "R5 config upper bits dropped");

        // clear and run (R2, R3)
        wr(12'h108, 32'h0000_0013);
        rd(12'h108, 32'h0000_0003, "R2 R3 control readback, clear bit reads 0");
        repeat (2) @(negedge clk);
        pulse(13, 5);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            pulse(5, 2);
            repeat (2) @(negedge clk);
        end
        pulse(0, 4);
        repeat (2) @(negedge clk);
        wr(12'h108, 32'h0);
        rdcnt(0, 64'd5, "R6 level count, selector 0x3D wraps to input 13");
        rdcnt(3, 64'd5, "R6 level count, selector 0x12D wraps to input 13");
        rdcnt(1, 64'd3, "R7 rising edge count");
        rdcnt(2, 64'd3, "R8 falling edge count");
        rdcnt(4, 64'd0, "R6 idle input gives zero");
        rdcnt(5, 64'd4, "R6 default config counts input 0");
        rdcnt(7, 64'd4, "R9 select 15 picks counter 7");

        // stop / armed / start-only (R4, R2)
        pulse(13, 3);
        rdcnt(0, 64'd5, "R4 stopped counter holds");
        wr(12'h108, 32'h1);
        pulse(13, 3);
        rdcnt(0, 64'd5, "R4 enable alone does not count");
        wr(12'h108, 32'h2);
        pulse(13, 3);
        rdcnt(0, 64'd5, "R2 start without enable does not count");
        rd(12'h108, 32'h2, "R2 start bit readback");
        wr(12'h108, 32'h3);
        pulse(13, 2);
        wr(12'h108, 32'h0);
        rdcnt(0, 64'd7, "R4 resume continues from held value");

        // snapshot consistency (R10)
        wr(12'h12C, 32'd8);
        rd(12'h134, 32'd0, "R10 high word");
        wr(12'h108, 32'h3);
        pulse(13, 3);
        rd(12'h130, 32'd7, "R10 low word from captured value");
        wr(12'h108, 32'h0);
        rd(12'h134, 32'd0, "R10 high word recapture");
        rd(12'h130, 32'd10, "R10 low word after recapture");

        // out-of-range select (R11, R9)
        wr(12'h12C, 32'd7);
        rd(12'h134, 32'd0, "R11 select 7 high");
        rd(12'h130, 32'd0, "R11 select 7 low");
        wr(12'h12C, 32'd16);
        rd(12'h134, 32'd0, "R11 select 16 high");
        wr(12'h12C, 32'h0000_0108);
        rd(12'h130, 32'd0, "R11 select 0x108 low");
        rd(12'h12C, 32'h0000_0108, "R9 select readback");

        // clear cycle loses exactly one edge (R3)
        wr(12'h108, 32'h13);
        pulse(13, 3);
        wr(12'h108, 32'h0);
        rdcnt(0, 64'd2, "R3 clear edge not counted, then resumes");
        rdcnt(7, 64'd0, "R3 all counters cleared");

        // unmapped (R12)
        rd(12'h000, 32'd0, "R12 unmapped address 0x000");
        rd(12'h200, 32'd0, "R12 unmapped address 0x200");

        repeat (4) @(negedge clk);
        check(q_exp.size() == 0, "R12 all reads answered", 32'(q_exp.size()), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule